// File: doc/BRIEF.md
# Channel Request Translator with Controller Registers

This block sits at the front of a packet-based DRAM channel controller. A single request port carries system reads and writes with a byte address. Requests aimed at main memory or at the device-register window are turned into one command descriptor on a valid/ready output: a read/write flag, a 36-bit channel address and a broadcast flag. Memory and register accesses slice the address differently. A register access copies one 9-bit field into both row-side slices, so that address swapping inside the devices leaves register accesses untouched. The upper half of the register window is a broadcast write that reaches every device.

A separate page of the address space holds the controller's own registers. These are a mode register (operating mode and two clock auto-stop enables), a current-control configuration register (manual code plus an automatic-calibration enable), and a write-only load strobe. The strobe copies either the manual code or the calibrated code from an input port onto the current-control output. Register accesses, and requests that cannot be forwarded, complete on a one-cycle response pulse. After a change of operating mode, or after a load that uses the calibrated code, the request port stays closed for a programmable settle time.

Top module: `chan_req_xlate`

## Requirements
- R1: A request with address below 0x3F00000 becomes a command with cmd_bcast=0, the request's write flag, and channel bits [28:20]=addr[25:20] (zero-extended), [19:11]=addr[19:11] and [10:0]=addr[10:0].
- R2: A request with address in 0x3F00000–0x3FFFFFF becomes a command whose channel bits [28:20] and [19:11] both carry addr[18:10], bit 10 is zero and bits [9:0]=addr[9:0]. cmd_bcast equals addr[19].
- R3: Channel address bits [35:29] are zero on every command.
- R4: A read with addr[19]=1 inside the register window produces no command. It produces a response with rsp_err=1 and rsp_rdata=0.
- R5: An address of 0x4000000 or above that is outside the control page (address bits [27:20]=0x47) produces no command. It produces a response with rsp_err=1.
- R6: The mode register at control offset 0x0 holds operating mode in bits [1:0] (0 reset, 1 active, 2 standby), tx auto-stop in bit 2 and rx auto-stop in bit 3. It resets to standby with both stops off, and the other bits read as zero.
- R7: The configuration register at offset 0x4 holds the manual code in bits [5:0] and the auto-calibration enable in bit 6. It resets to zero, and the other bits read as zero.
- R8: A write to offset 0x8 loads cc_code with cal_code when auto-calibration is 1, and with the manual code when it is 0. Offset 0x8 and all unlisted control offsets read as zero, and writes to unlisted offsets change nothing.
- R9: A mode-register write that changes the operating mode holds req_ready low for MODE_SETTLE cycles. A write that keeps the same mode adds no hold.
- R10: A load with auto-calibration enabled holds req_ready low for CAL_SETTLE cycles. A manual load adds no hold.
- R11: A command stays valid and unchanged until cmd_ready is high, and req_ready is low while a command is pending.
- R12: Every accepted request yields, in the next cycle, exactly one of a new command or a response pulse. Control-register accesses respond with rsp_err=0, and writes return rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data for control registers |
| cmd_valid | output | 1 | Command descriptor present |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | 36 | Channel address |
| cmd_bcast | output | 1 | Broadcast register write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response reports an error |
| rsp_rdata | output | 32 | Control-register read data |
| cal_code | input | CC_W | Internally calibrated current code |
| op_mode | output | 2 | Operating mode field |
| rx_stop_en | output | 1 | Receive clock auto-stop enable |
| tx_stop_en | output | 1 | Transmit clock auto-stop enable |
| cc_code | output | CC_W | Current-control register |

## Verification
Two functions can meet in one cycle. The first is the release of a settle hold. The second is a request that has been waiting on the port. The bench raises a request straight after a mode change and straight after a calibrated load, and keeps it asserted through the hold. The cycle-level model then requires acceptance on exactly the first cycle both counters read zero. A command stalled by cmd_ready low is also made to overlap a waiting request, and the model requires req_ready to stay low until the command is taken.

// File: rtl/chan_xlate_pkg.sv
package chan_xlate_pkg;

    typedef enum logic [1:0] {
        RG_MEM  = 2'd0,
        RG_DREG = 2'd1,
        RG_CTRL = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        OPM_RESET   = 2'd0,
        OPM_ACTIVE  = 2'd1,
        OPM_STANDBY = 2'd2,
        OPM_SPARE   = 2'd3
    } opmode_e;

    localparam int CHAN_AW = 36;

    localparam logic [19:0] OFF_MODE = 20'h0_0000;
    localparam logic [19:0] OFF_CFG  = 20'h0_0004;
    localparam logic [19:0] OFF_LOAD = 20'h0_0008;

endpackage

// File: rtl/chan_addr_map.sv
module chan_addr_map
    import chan_xlate_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int CTRL_PAGE = 'h47
) (
    input  logic [ADDR_W-1:0]  addr,
    output region_e            region,
    output logic [CHAN_AW-1:0] chan_addr,
    output logic               bcast,
    output logic [19:0]        ctrl_off
);
    localparam int PAGE_W = ADDR_W - 20;
    localparam logic [PAGE_W-1:0] DREG_PAGE = PAGE_W'('h3F);
    localparam logic [PAGE_W-1:0] CTL_PAGE  = PAGE_W'(CTRL_PAGE);

    logic [PAGE_W-1:0] page;
    logic [8:0]        reg_field;

    assign page      = addr[ADDR_W-1:20];
    assign reg_field = addr[18:10];
    assign ctrl_off  = addr[19:0];

    always_comb begin
        chan_addr = '0;
        bcast     = 1'b0;
        if (page < DREG_PAGE) begin
            region    = RG_MEM;
            chan_addr = {10'd0, addr[25:20], addr[19:11], addr[10:0]};
        end else if (page == DREG_PAGE) begin
            region    = RG_DREG;
            bcast     = addr[19];
            chan_addr = {7'd0, reg_field, reg_field, 1'b0, addr[9:0]};
        end else if (page == CTL_PAGE) begin
            region = RG_CTRL;
        end else begin
            region = RG_NONE;
        end
    end

endmodule

// File: rtl/chan_settle_timer.sv
module chan_settle_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy); // R9

endmodule

// File: rtl/chan_req_xlate.sv
module chan_req_xlate
    import chan_xlate_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int CTRL_PAGE   = 'h47,
    parameter int MODE_SETTLE = 16,
    parameter int CAL_SETTLE  = 64,
    parameter int CC_W        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [35:0]       cmd_addr,
    output logic              cmd_bcast,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [CC_W-1:0]   cal_code,
    output logic [1:0]        op_mode,
    output logic              rx_stop_en,
    output logic              tx_stop_en,
    output logic [CC_W-1:0]   cc_code
);
    typedef struct packed {
        opmode_e              mode;
        logic                 rx_stop;
        logic                 tx_stop;
        logic                 auto_cc;
        logic [CC_W-1:0]      man_cc;
        logic [CC_W-1:0]      cc;
        logic                 cmd_valid;
        logic                 cmd_write;
        logic [CHAN_AW-1:0]   cmd_addr;
        logic                 cmd_bcast;
        logic                 rsp_valid;
        logic                 rsp_err;
        logic [31:0]          rsp_rdata;
    } state_t;

    state_t st_d, st_q;

    region_e            map_region;
    logic [CHAN_AW-1:0] map_addr;
    logic               map_bcast;
    logic [19:0]        map_off;
    logic               mode_load, cal_load;
    logic               mode_busy, cal_busy;
    logic               acc;

    chan_addr_map #(
        .ADDR_W    (ADDR_W),
        .CTRL_PAGE (CTRL_PAGE)
    ) u_map (
        .addr      (req_addr),
        .region    (map_region),
        .chan_addr (map_addr),
        .bcast     (map_bcast),
        .ctrl_off  (map_off)
    );

    chan_settle_timer #(.LEN(MODE_SETTLE)) u_mode_tmr (
        .clk (clk), .rst_n (rst_n), .load (mode_load), .busy (mode_busy)
    );

    chan_settle_timer #(.LEN(CAL_SETTLE)) u_cal_tmr (
        .clk (clk), .rst_n (rst_n), .load (cal_load), .busy (cal_busy)
    );

    assign req_ready = !mode_busy && !cal_busy && !st_q.cmd_valid;
    assign acc       = req_valid && req_ready;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_rdata = '0;
        mode_load      = 1'b0;
        cal_load       = 1'b0;

        if (st_q.cmd_valid && cmd_ready) st_d.cmd_valid = 1'b0;

        if (acc) begin
            unique case (map_region)
                RG_MEM: begin
                    st_d.cmd_valid = 1'b1;
                    st_d.cmd_write = req_write;
                    st_d.cmd_addr  = map_addr;
                    st_d.cmd_bcast = 1'b0;
                end
                RG_DREG: begin
                    if (map_bcast && !req_write) begin
                        st_d.rsp_valid = 1'b1;
                        st_d.rsp_err   = 1'b1;
                    end else begin
                        st_d.cmd_valid = 1'b1;
                        st_d.cmd_write = req_write;
                        st_d.cmd_addr  = map_addr;
                        st_d.cmd_bcast = map_bcast;
                    end
                end
                RG_CTRL: begin
                    st_d.rsp_valid = 1'b1;
                    if (req_write) begin
                        if (map_off == OFF_MODE) begin
                            mode_load    = (req_wdata[1:0] != st_q.mode);
                            st_d.mode    = opmode_e'(req_wdata[1:0]);
                            st_d.tx_stop = req_wdata[2];
                            st_d.rx_stop = req_wdata[3];
                        end else if (map_off == OFF_CFG) begin
                            st_d.man_cc  = req_wdata[CC_W-1:0];
                            st_d.auto_cc = req_wdata[CC_W];
                        end else if (map_off == OFF_LOAD) begin
                            st_d.cc  = st_q.auto_cc ? cal_code : st_q.man_cc;
                            cal_load = st_q.auto_cc;
                        end
                    end else begin
                        if (map_off == OFF_MODE) begin
                            st_d.rsp_rdata = {28'd0, st_q.rx_stop, st_q.tx_stop, st_q.mode};
                        end else if (map_off == OFF_CFG) begin
                            st_d.rsp_rdata = 32'({st_q.auto_cc, st_q.man_cc});
                        end
                    end
                end
                default: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= OPM_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid  = st_q.cmd_valid;
    assign cmd_write  = st_q.cmd_write;
    assign cmd_addr   = st_q.cmd_addr;
    assign cmd_bcast  = st_q.cmd_bcast;
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_err    = st_q.rsp_err;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign op_mode    = st_q.mode;
    assign rx_stop_en = st_q.rx_stop;
    assign tx_stop_en = st_q.tx_stop;
    assign cc_code    = st_q.cc;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write) && $stable(cmd_bcast)); // R11
    AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready); // R11
    AST_BCAST_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_bcast |-> cmd_write); // R4
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_addr[35:29] == 7'd0); // R3
    AST_MODE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(op_mode) |-> !req_ready); // R9
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (cmd_valid ^ rsp_valid)); // R12

endmodule

// File: tb/tb_chan_req_xlate.sv
module tb_chan_req_xlate;
    localparam int ADDR_W = 28;
    localparam int MODE_N = 16;
    localparam int CAL_N  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, cmd_ready = 1'b1;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [5:0]        cal_code = '0;
    logic              req_ready, cmd_valid, cmd_write, cmd_bcast;
    logic              rsp_valid, rsp_err, rx_stop_en, tx_stop_en;
    logic [35:0]       cmd_addr;
    logic [31:0]       rsp_rdata;
    logic [1:0]        op_mode;
    logic [5:0]        cc_code;

    always #5 clk = ~clk;

    chan_req_xlate #(.ADDR_W(ADDR_W), .MODE_SETTLE(MODE_N), .CAL_SETTLE(CAL_N)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_bcast(cmd_bcast), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cal_code(cal_code),
        .op_mode(op_mode), .rx_stop_en(rx_stop_en), .tx_stop_en(tx_stop_en),
        .cc_code(cc_code)
    );

    int    checks = 0;
    int    errs   = 0;
    string cur    = "R6";

    // behavioural reference state
    int          m_mode = 2, m_mcnt = 0, m_ccnt = 0;
    bit          m_rx = 0, m_tx = 0, m_auto = 0;
    int          m_man = 0, m_cc = 0;
    bit          m_cv = 0, m_cw = 0, m_cb = 0, m_rv = 0, m_re = 0;
    longint      m_ca = 0;
    longint      m_rd = 0;
    bit          last_acc = 0;

    function automatic bit m_ready();
        return (m_mcnt == 0) && (m_ccnt == 0) && !m_cv;
    endfunction

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("req_ready", longint'(req_ready), longint'(m_ready()));
        chk("cmd_valid", longint'(cmd_valid), longint'(m_cv));
        if (m_cv) begin
            chk("cmd_write", longint'(cmd_write), longint'(m_cw));
            chk("cmd_addr", longint'(cmd_addr), m_ca);
            chk("cmd_bcast", longint'(cmd_bcast), longint'(m_cb));
        end
        chk("rsp_valid", longint'(rsp_valid), longint'(m_rv));
        if (m_rv) begin
            chk("rsp_err", longint'(rsp_err), longint'(m_re));
            chk("rsp_rdata", longint'(rsp_rdata), m_rd);
        end
        chk("op_mode", longint'(op_mode), longint'(m_mode));
        chk("rx_stop_en", longint'(rx_stop_en), longint'(m_rx));
        chk("tx_stop_en", longint'(tx_stop_en), longint'(m_tx));
        chk("cc_code", longint'(cc_code), longint'(m_cc));
    endtask

    // one clock: predict from current inputs, step, compare at negedge
    task automatic cycle();
        int     n_mode = m_mode, n_mcnt, n_ccnt, n_man = m_man, n_cc = m_cc;
        bit     n_rx = m_rx, n_tx = m_tx, n_auto = m_auto;
        bit     n_cv = m_cv, n_cw = m_cw, n_cb = m_cb, n_rv = 0, n_re = 0;
        longint n_ca = m_ca, n_rd = 0;
        bit     mload = 0, cload = 0;
        bit     acc = req_valid && m_ready();
        longint a = longint'(req_addr);
        longint off = a & 64'hFFFFF;
        if (m_cv && cmd_ready) n_cv = 0;
        if (acc) begin
            if (a < 64'h3F00000) begin
                n_cv = 1; n_cw = req_write; n_cb = 0;
                n_ca = (((a >> 20) & 63) << 20) | (((a >> 11) & 511) << 11) | (a & 2047);
            end else if (a < 64'h4000000) begin
                if (((a >> 19) & 1) == 1 && !req_write) begin
                    n_rv = 1; n_re = 1;
                end else begin
                    longint f = (a >> 10) & 511;
                    n_cv = 1; n_cw = req_write; n_cb = bit'((a >> 19) & 1);
                    n_ca = (f << 20) | (f << 11) | (a & 1023);
                end
            end else if ((a >> 20) == 64'h47) begin
                n_rv = 1;
                if (req_write) begin
                    if (off == 0) begin
                        if (int'(req_wdata[1:0]) != m_mode) mload = 1;
                        n_mode = int'(req_wdata[1:0]);
                        n_tx = req_wdata[2]; n_rx = req_wdata[3];
                    end else if (off == 4) begin
                        n_man = int'(req_wdata[5:0]); n_auto = req_wdata[6];
                    end else if (off == 8) begin
                        n_cc = m_auto ? int'(cal_code) : m_man;
                        cload = m_auto;
                    end
                end else begin
                    if (off == 0) n_rd = (m_rx ? 8 : 0) + (m_tx ? 4 : 0) + m_mode;
                    else if (off == 4) n_rd = (m_auto ? 64 : 0) + m_man;
                end
            end else begin
                n_rv = 1; n_re = 1;
            end
        end
        n_mcnt = mload ? MODE_N : (m_mcnt > 0 ? m_mcnt - 1 : 0);
        n_ccnt = cload ? CAL_N : (m_ccnt > 0 ? m_ccnt - 1 : 0);
        last_acc = acc;
        @(posedge clk);
        m_mode = n_mode; m_mcnt = n_mcnt; m_ccnt = n_ccnt; m_rx = n_rx; m_tx = n_tx;
        m_auto = n_auto; m_man = n_man; m_cc = n_cc; m_cv = n_cv; m_cw = n_cw;
        m_cb = n_cb; m_ca = n_ca; m_rv = n_rv; m_re = n_re; m_rd = n_rd;
        @(negedge clk);
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic do_req(string tag, bit w, longint a, logic [31:0] d);
        cur = tag;
        req_valid = 1; req_write = w; req_addr = ADDR_W'(a); req_wdata = d;
        last_acc = 0;
        while (!last_acc) cycle();
        req_valid = 0; req_write = 0; req_wdata = '0;
    endtask

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        cur = "R6";
        compare();                              // R6 reset state
        idle(2);
        do_req("R6", 0, 28'h4700000, 0);       // R6 default standby
        do_req("R8", 0, 28'h4700008, 0);       // R8 load offset reads zero
        do_req("R8", 1, 28'h4700010, 32'hFF);  // R8 unlisted offset ignored
        do_req("R8", 0, 28'h4700010, 0);
        // R9 mode change, a request waits through the hold
        do_req("R9", 1, 28'h4700000, 32'h0000_000D);
        do_req("R9", 0, 28'h4700000, 0);
        do_req("R9", 1, 28'h4700000, 32'hFFFF_FFF1); // same mode, no hold
        do_req("R6", 0, 28'h4700000, 0);
        do_req("R9", 1, 28'h4700000, 32'h0000_0000); // to reset mode
        // R7 configuration
        do_req("R7", 1, 28'h4700004, 32'hFFFF_FF2A);
        do_req("R7", 0, 28'h4700004, 0);
        // R8 / R10 manual load, no hold
        cal_code = 6'h15;
        do_req("R10", 1, 28'h4700008, 0);
        do_req("R7", 1, 28'h4700004, 32'h0000_006A);
        do_req("R7", 0, 28'h4700004, 0);
        // R10 calibrated load, request waits through the hold
        do_req("R10", 1, 28'h4700008, 0);
        cal_code = 6'h3C;
        do_req("R10", 0, 28'h4700008, 0);
        // R1 memory space
        do_req("R1", 0, 28'h03ABCDE, 0);
        idle(1);
        do_req("R1", 1, 28'h3EFFFFF, 0);
        do_req("R1", 0, 28'h0000000, 0);
        // R2 / R3 device registers
        do_req("R2", 1, 28'h3F00808, 0);
        do_req("R2", 0, 28'h3F7FFFF, 0);
        do_req("R3", 1, 28'h3F80008, 0);
        do_req("R2", 1, 28'h3FFFFFF, 0);
        // R4 broadcast read rejected
        do_req("R4", 0, 28'h3F80000, 0);
        do_req("R4", 0, 28'h3FC1234, 0);
        // R5 outside every window
        do_req("R5", 0, 28'h4000000, 0);
        do_req("R5", 1, 28'h4800000, 0);
        do_req("R5", 0, 28'hFFFFFFF, 0);
        // R11 downstream stall with a waiting request
        cmd_ready = 0;
        do_req("R11", 0, 28'h0123456, 0);
        req_valid = 1; req_write = 1; req_addr = 28'h3F01400;
        idle(4);
        cmd_ready = 1;
        do_req("R11", 1, 28'h3F01400, 0);
        // R12 back-to-back mix
        do_req("R12", 1, 28'h4700000, 32'h2);
        do_req("R12", 0, 28'h0200000, 0);
        do_req("R12", 0, 28'h4700004, 0);
        idle(3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule